// File: doc/BRIEF.md
# Central-Limit Noise Accumulator

This block smooths a stream of quantized, roughly Gaussian noise samples by summing a fixed group of consecutive samples, as the central limit theorem suggests. Each incoming sample is a signed fixed-point word with `FRAC_BITS` fractional bits. The upstream generator forms negative values with a one's complement, so every sample carries a mean bias of minus half an LSB. A group of `2**LOG2_A` samples therefore carries a bias of `-(A/2)` input LSBs. The block adds that amount back once per group, so the corrected sum has zero mean.

The sum has a standard deviation of `sqrt(A)` input units. No multiplier is used to undo this. The output word is read with `LOG2_A/2` more fractional bits than the input, which moves the binary point left and divides the value by `sqrt(A)`. In the default configuration (A = 4, 9-bit input with 6 fractional bits) the output is an 11-bit signed word with 7 fractional bits. One result leaves the block for every A accepted input samples. A new group starts at reset and after each completed group.

Top module: `clt_noise_accum`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block clears its group count, its running sum, `out_valid` and `out_data` to 0.
- R2: `out_valid` is high for exactly one cycle: the cycle after the clock edge that accepts the A-th valid sample of a group. At every other time it is low.
- R3: After reset, `out_valid` stays low until A samples have been accepted, no matter how many cycles pass.
- R4: A cycle with `in_valid` low has no effect, whatever `in_data` holds: it is not counted and not summed.
- R5: When `out_valid` is high, `out_data` equals the two's-complement sum of the group's A samples plus A/2 input LSBs. It is read as signed with `FRAC_BITS + LOG2_A/2` fractional bits.
- R6: `out_data` holds its value in every cycle in which `out_valid` is low.
- R7: Each group starts from a zero sum: a result never depends on samples from an earlier group.
- R8: No input pattern overflows the output. A group of all most-positive or all most-negative samples gives the exact corrected sum (default: +1022 and -1022 output LSBs).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Marks `in_data` as a sample to accept this cycle |
| in_data | input | IN_W | Signed sample, FRAC_BITS fractional bits |
| out_valid | output | 1 | One-cycle pulse when a group result is ready |
| out_data | output | IN_W+LOG2_A | Signed corrected group sum, FRAC_BITS+LOG2_A/2 fractional bits |

## Verification
A long random stream is used, with valid strobes missing about a third of the time and with random data sitting on the bus during idle cycles. This separates correct group counting from counting clock cycles or leaking idle data into a sum. Groups of all-maximum and all-minimum samples test the width and sign extension. All-zero and all-minus-one groups isolate the fixed mean correction from the data. A reset in the middle of a group shows whether any partial sum or count survives into the next result.

// File: rtl/clt_pkg.sv
// Shared helpers for the central-limit noise accumulator.
// Assumes group sizes are powers of two.
package clt_pkg;

    // Mean correction in input LSBs for a group of 2**log2_a samples:
    // each sample is biased by -1/2 LSB, so the group needs +A/2.
    function automatic int unsigned group_bias_lsb(input int unsigned log2_a);
        return (32'd1 << log2_a) >> 1;
    endfunction

endpackage

// File: rtl/clt_group_ctr.sv
// Group counter: counts accepted samples modulo A = 2**LOG2_A.
// Flags the first and the last position of the current group.
// Assumes LOG2_A >= 1. Synchronous active-low reset.
module clt_group_ctr #(
    parameter int LOG2_A = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic in_valid,
    output logic first,
    output logic last
);
    localparam int A = 1 << LOG2_A;

    logic [LOG2_A-1:0] cnt;

    // Position decode for the sample presented this cycle.
    always_comb begin
        first = (cnt == '0);
        last  = (cnt == LOG2_A'(A - 1));
    end

    // Advance once per accepted sample, wrapping after A.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (in_valid)
            cnt <= last ? '0 : cnt + 1'b1;
    end

    // R4: idle cycles leave the count untouched
    a_r4_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(cnt));

    // R2: a completed group always brings the count back to zero
    a_r2_wrap_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && last) |=> (cnt == '0));

endmodule

// File: rtl/clt_group_sum.sv
// Group summer: accumulates sign-extended samples and, on the last
// sample of a group, registers the sum plus the mean correction.
// The wider word needs no saturation: A*(2**(IN_W-1)-1)+A/2 fits.
// Synchronous active-low reset.
module clt_group_sum #(
    parameter int IN_W   = 9,
    parameter int LOG2_A = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    input  logic [IN_W-1:0]          in_data,
    input  logic                     first,
    input  logic                     last,
    output logic                     out_valid,
    output logic [IN_W+LOG2_A-1:0]   out_data
);
    localparam int SUM_W = IN_W + LOG2_A;
    localparam logic [SUM_W-1:0] CORR = SUM_W'(clt_pkg::group_bias_lsb(LOG2_A));

    logic [SUM_W-1:0] acc;
    logic [SUM_W-1:0] in_ext;
    logic [SUM_W-1:0] partial;

    // Sign-extend the sample and add it to a fresh or running sum.
    always_comb begin
        in_ext  = {{LOG2_A{in_data[IN_W-1]}}, in_data};
        partial = (first ? '0 : acc) + in_ext;
    end

    // Running sum update and result register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc       <= '0;
            out_data  <= '0;
            out_valid <= 1'b0;
        end else begin
            out_valid <= in_valid && last;
            if (in_valid)
                acc <= partial;
            if (in_valid && last)
                out_data <= partial + CORR;
        end
    end

    // R7: the first sample of a group replaces, not extends, the sum
    a_r7_fresh_group: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && first) |=> (acc == {{LOG2_A{$past(in_data[IN_W-1])}}, $past(in_data)}));

    // R6: result only moves together with the valid pulse
    a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> $stable(out_data));

endmodule

// File: rtl/clt_noise_accum.sv
// Central-limit noise accumulator top level.
// Sums A = 2**LOG2_A valid samples, adds A/2 LSBs to cancel the
// one's-complement bias, and outputs the result with LOG2_A/2 more
// fractional bits so the deviation is divided by sqrt(A).
// Assumes LOG2_A is even and >= 2. Synchronous active-low reset.
module clt_noise_accum #(
    parameter int IN_W      = 9,
    parameter int FRAC_BITS = 6,
    parameter int LOG2_A    = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   in_valid,
    input  logic [IN_W-1:0]        in_data,
    output logic                   out_valid,
    output logic [IN_W+LOG2_A-1:0] out_data
);
    // Output fraction width: the binary-point shift is the scaling.
    localparam int OUT_FRAC = FRAC_BITS + LOG2_A / 2;

    logic first;
    logic last;

    clt_group_ctr #(.LOG2_A(LOG2_A)) i_ctr (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .first    (first),
        .last     (last)
    );

    clt_group_sum #(.IN_W(IN_W), .LOG2_A(LOG2_A)) i_sum (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .first     (first),
        .last      (last),
        .out_valid (out_valid),
        .out_data  (out_data)
    );

    // R2: the pulse never lasts longer than one cycle
    a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);

    // R3: a pulse always follows an accepted group-closing sample
    a_r3_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_valid && last));

    // Parameter sanity for the shift-based scaling
    initial a_r5_frac_even: assert (LOG2_A % 2 == 0 && OUT_FRAC > FRAC_BITS);

endmodule

// File: tb/test_clt_noise_accum.sv
// Bench: random gapped stream plus directed groups, checked against a
// behavioural model of the corrected group sum.
module test_clt_noise_accum;
    localparam int IN_W   = 9;
    localparam int LOG2_A = 2;
    localparam int A      = 1 << LOG2_A;
    localparam int OUT_W  = IN_W + LOG2_A;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             in_valid = 1'b0;
    logic [IN_W-1:0]  in_data = '0;
    logic             out_valid;
    logic [OUT_W-1:0] out_data;

    int    n_chk = 0;
    int    n_fail = 0;
    int    grp_cnt = 0;
    int    grp_sum = 0;
    int    last_out = 0;
    bit    pending = 1'b1;
    bit    idle_seen = 1'b0;
    bit    done = 1'b0;
    string tag = "";

    always #4 clk = ~clk;

    clt_noise_accum #(.IN_W(IN_W), .FRAC_BITS(6), .LOG2_A(LOG2_A)) i_clt_noise_accum (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .out_valid(out_valid), .out_data(out_data)
    );

    function automatic int expect_out(input int s);
        logic [OUT_W-1:0] v;
        v = OUT_W'(s + A / 2);
        return int'($signed(v));
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One clock: drive, let the edge pass, compare with the model.
    task automatic cycle(input bit v, input int d);
        bit    exp_v;
        string req;
        in_valid = v;
        in_data  = IN_W'(d);
        @(posedge clk);
        #2;
        exp_v = 1'b0;
        if (v) begin
            grp_sum += d;
            grp_cnt++;
        end else begin
            idle_seen = 1'b1;
        end
        req = pending ? "R3" : "R2";
        if (grp_cnt == A) begin
            exp_v = 1'b1;
            last_out = expect_out(grp_sum);
        end
        check(req, int'(out_valid), int'(exp_v));
        if (exp_v) begin
            if (tag != "")      req = tag;
            else if (idle_seen) req = "R4";
            else if (pending)   req = "R5";
            else                req = "R7";
            check(req, int'($signed(out_data)), last_out);
            grp_sum = 0; grp_cnt = 0; pending = 1'b0; idle_seen = 1'b0;
        end else begin
            check("R6", int'($signed(out_data)), last_out);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        in_valid = 1'b0;
        repeat (3) @(posedge clk);
        #2;
        check("R1", int'(out_valid), 0);
        check("R1", int'($signed(out_data)), 0);
        grp_cnt = 0; grp_sum = 0; last_out = 0; pending = 1'b1; idle_seen = 1'b0;
        rst_n = 1'b1;
    endtask

    initial begin
        int unsigned seed;
        seed = $urandom(32'd2718);
        do_reset();
        // R3: many idle cycles with noisy data, then three samples: no pulse
        for (int i = 0; i < 20; i++) cycle(1'b0, int'($urandom % 512) - 256);
        for (int i = 0; i < 3; i++) cycle(1'b1, 17 * i - 5);
        cycle(1'b0, 200);
        cycle(1'b1, 9);
        // R5: zero group gives just the correction (+2)
        tag = "R5";
        for (int i = 0; i < A; i++) cycle(1'b1, 0);
        // R5: all minus one gives -4 + 2 = -2
        for (int i = 0; i < A; i++) cycle(1'b1, -1);
        // R8: extremes
        tag = "R8";
        for (int i = 0; i < A; i++) cycle(1'b1, 255);
        for (int i = 0; i < A; i++) cycle(1'b1, -256);
        tag = "";
        // R1: reset mid-group drops the partial sum and count
        cycle(1'b1, 100);
        cycle(1'b1, 100);
        do_reset();
        for (int i = 0; i < A; i++) cycle(1'b1, -30 + i);
        // Random gapped stream
        for (int i = 0; i < 4000; i++)
            cycle(($urandom % 10) < 7, int'($urandom % 512) - 256);
        cycle(1'b0, 0);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL R2 watchdog actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule